// File: doc/BRIEF.md
# Interrupt Request Controller with Master Enable

This block collects interrupt events from up to eight sources, keeps one request flag per source, gates each flag with its own enable bit, and gates everything with a single master enable. It presents a registered interrupt request and the index of the winning source to the processor core. The core answers with an acknowledge strobe on handler entry and a return strobe on handler exit.

Software reaches the state through a write port with three register targets: an enable mask, a request-flag register and a control register that holds the master enable. Each write replaces a whole byte or sets or clears one addressed bit. On acknowledge, the hardware clears the master enable and the flag of the source being served. On return, it sets the master enable again. A handler that wants to be interrupted by other sources sets the master enable itself.

Top module: `intc_core`

## Requirements
- R1: While `rst` is high, and at the first edge after it, all enable bits, request flags and the master enable are zero, and `irq_o` = 0, `vec_o` = 0.
- R2: A 0-to-1 change on `src_i[i]` between two consecutive clock edges sets request flag i. A source held high sets its flag only once.
- R3: Write targets by `wr_addr_i`: 0 is the enable mask, 1 the request flags, 2 the control register with the master enable in bit 0. Writes to address 3 are ignored. `wr_op_i` selects the write: 0 loads `wr_data_i`, 1 sets bit `wr_bit_i`, 2 clears bit `wr_bit_i`, and 3 is ignored.
- R4: `irq_o` is 1 exactly when the master enable is 1 and at least one flag is set whose enable bit is also 1. It reflects every state change made at a clock edge from that same edge onward.
- R5: `vec_o` is the lowest index i whose flag and enable bit are both 1, whatever the master enable holds. It is 0 when there is no such index.
- R6: `ack_i` high at an edge clears the master enable and clears the request flag of the source currently shown on `vec_o`.
- R7: `reti_i` high at an edge sets the master enable. When `ack_i` and `reti_i` are high at the same edge, the master enable ends up cleared.
- R8: Inside a handler, a software write that sets the master enable makes `irq_o` rise again for sources that are still pending and enabled.
- R9: A source rising edge wins over an acknowledge or a software clear of the same flag at the same edge, so the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NSRC | Interrupt source levels; a rising edge raises a request |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write target: 0 enables, 1 flags, 2 control |
| wr_op_i | input | 2 | 0 load byte, 1 set bit, 2 clear bit, 3 none |
| wr_bit_i | input | $clog2(REG_W) | Bit index for set and clear |
| wr_data_i | input | REG_W | Byte for the load operation |
| ack_i | input | 1 | Core enters the handler for the source on `vec_o` |
| reti_i | input | 1 | Core returns from a handler |
| irq_o | output | 1 | Interrupt request to the core |
| vec_o | output | $clog2(NSRC) | Index of the highest-priority pending enabled source |

## Verification
The assertions assume that the core raises `ack_i` only while `irq_o` is high, and that it serves the index shown on `vec_o` in that cycle. They also assume that at most one software write arrives per cycle. The acknowledge-clears-flag check is therefore qualified against a same-cycle rising edge or flag write. The stimulus raises `ack_i` only in cycles that follow a high `irq_o`, and it raises `reti_i` only after an acknowledge. Sources stay at a level for at least one full cycle, so every intended edge is seen exactly once.

// File: rtl/intc_pkg.sv
package intc_pkg;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_NONE = 2'd3
  } wr_op_e;

  localparam logic [1:0] ADDR_ENABLE  = 2'd0;
  localparam logic [1:0] ADDR_FLAGS   = 2'd1;
  localparam logic [1:0] ADDR_CONTROL = 2'd2;

  localparam int MASTER_BIT = 0;

  function automatic logic apply_op(input logic cur, input wr_op_e op,
                                    input logic sel, input logic din);
    case (op)
      OP_LOAD: apply_op = din;
      OP_SET:  apply_op = sel ? 1'b1 : cur;
      OP_CLR:  apply_op = sel ? 1'b0 : cur;
      default: apply_op = cur;
    endcase
  endfunction

endpackage

// File: rtl/intc_edge.sv
module intc_edge #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_i,
  output logic [NSRC-1:0] rise_o
);

  logic [NSRC-1:0] src_q;

  always_ff @(posedge clk) begin
    if (rst) src_q <= '0;
    else     src_q <= src_i;
  end

  assign rise_o = src_i & ~src_q;

endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
  parameter int NSRC = 8,
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]  req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);

  // scan from the top down so the lowest set index is the last one kept
  always_comb begin
    idx_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |req_i;

endmodule

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int REG_W = 8,
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int BIT_W = (REG_W > 1) ? $clog2(REG_W) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  rise_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  wr_op_e           wr_op_i,
  input  logic [BIT_W-1:0] wr_bit_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             ack_i,
  input  logic [IDX_W-1:0] ack_idx_i,
  input  logic             reti_i,
  output logic [NSRC-1:0]  en_q_o,
  output logic [NSRC-1:0]  pend_q_o,
  output logic             master_q_o,
  output logic [NSRC-1:0]  en_n_o,
  output logic [NSRC-1:0]  pend_n_o,
  output logic             master_n_o
);

  logic [NSRC-1:0] en_q, pend_q;
  logic            master_q;
  logic            hit_en, hit_flags, hit_ctl;

  assign hit_en    = wr_en_i && (wr_addr_i == ADDR_ENABLE);
  assign hit_flags = wr_en_i && (wr_addr_i == ADDR_FLAGS);
  assign hit_ctl   = wr_en_i && (wr_addr_i == ADDR_CONTROL);

  // per-source next state: software write, then acknowledge, then edge capture
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic sel;
    logic en_w, pend_w, pend_a;

    assign sel    = (wr_bit_i == BIT_W'(g));
    assign en_w   = hit_en ? apply_op(en_q[g], wr_op_i, sel, wr_data_i[g]) : en_q[g];
    assign pend_w = hit_flags ? apply_op(pend_q[g], wr_op_i, sel, wr_data_i[g]) : pend_q[g];
    assign pend_a = (ack_i && (ack_idx_i == IDX_W'(g))) ? 1'b0 : pend_w;

    assign en_n_o[g]   = en_w;
    assign pend_n_o[g] = pend_a | rise_i[g];
  end

  // master enable: software, then return, then entry (entry wins)
  always_comb begin
    master_n_o = master_q;
    if (hit_ctl)
      master_n_o = apply_op(master_q, wr_op_i, wr_bit_i == BIT_W'(MASTER_BIT),
                            wr_data_i[MASTER_BIT]);
    if (reti_i) master_n_o = 1'b1;
    if (ack_i)  master_n_o = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= '0;
      pend_q   <= '0;
      master_q <= 1'b0;
    end else begin
      en_q     <= en_n_o;
      pend_q   <= pend_n_o;
      master_q <= master_n_o;
    end
  end

  assign en_q_o     = en_q;
  assign pend_q_o   = pend_q;
  assign master_q_o = master_q;

  // R1: reset leaves every state bit cleared
  a_r1_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (en_q == '0 && pend_q == '0 && !master_q));

  // R2: a detected rising edge is held as a pending flag
  a_r2_edge_latches: assert property (@(posedge clk) disable iff (rst)
    (rise_i != '0) |=> ((pend_q & $past(rise_i)) == $past(rise_i)));

  // R6: entry clears the master enable
  a_r6_entry_drops_master: assert property (@(posedge clk) disable iff (rst)
    ack_i |=> !master_q);

  // R6: entry clears the served flag unless a new edge or flag write collides
  a_r6_ack_clears_flag: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !rise_i[ack_idx_i] && !hit_flags) |=> !pend_q[$past(ack_idx_i)]);

  // R7: return without entry sets the master enable
  a_r7_return_raises_master: assert property (@(posedge clk) disable iff (rst)
    (reti_i && !ack_i) |=> master_q);

endmodule

// File: rtl/intc_core.sv
module intc_core
  import intc_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int REG_W = 8,
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int BIT_W = (REG_W > 1) ? $clog2(REG_W) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  src_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [1:0]       wr_op_i,
  input  logic [BIT_W-1:0] wr_bit_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             ack_i,
  input  logic             reti_i,
  output logic             irq_o,
  output logic [IDX_W-1:0] vec_o
);

  logic [NSRC-1:0]  rise;
  logic [NSRC-1:0]  en_q, pend_q, en_n, pend_n;
  logic             master_q, master_n;
  logic             any_n;
  logic [IDX_W-1:0] idx_n;
  logic             irq_q;
  logic [IDX_W-1:0] vec_q;

  intc_edge #(.NSRC(NSRC)) u_edge (
    .clk   (clk),
    .rst   (rst),
    .src_i (src_i),
    .rise_o(rise)
  );

  intc_regs #(.NSRC(NSRC), .REG_W(REG_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .rise_i    (rise),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_op_i   (wr_op_e'(wr_op_i)),
    .wr_bit_i  (wr_bit_i),
    .wr_data_i (wr_data_i),
    .ack_i     (ack_i),
    .ack_idx_i (vec_q),
    .reti_i    (reti_i),
    .en_q_o    (en_q),
    .pend_q_o  (pend_q),
    .master_q_o(master_q),
    .en_n_o    (en_n),
    .pend_n_o  (pend_n),
    .master_n_o(master_n)
  );

  intc_prio #(.NSRC(NSRC)) u_prio (
    .req_i(pend_n & en_n),
    .any_o(any_n),
    .idx_o(idx_n)
  );

  // outputs registered from next state so they match the state registers
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      vec_q <= '0;
    end else begin
      irq_q <= master_n & any_n;
      vec_q <= idx_n;
    end
  end

  assign irq_o = irq_q;
  assign vec_o = vec_q;

  // R4: a request is raised only with the master enable and an enabled flag
  a_r4_irq_gated: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (master_q && ((pend_q & en_q) != '0)));

  // R4: an enabled pending flag with the master enable always requests
  a_r4_irq_complete: assert property (@(posedge clk) disable iff (rst)
    (master_q && ((pend_q & en_q) != '0)) |-> irq_o);

  // R5: the shown index is pending, enabled and has no lower competitor
  a_r5_vec_lowest: assert property (@(posedge clk) disable iff (rst)
    ((pend_q & en_q) != '0) |->
      (pend_q[vec_o] && en_q[vec_o] &&
       ((pend_q & en_q & ((NSRC'(1) << vec_o) - NSRC'(1))) == '0)));

endmodule

// File: tb/intc_core_test.sv
module intc_core_test;

  localparam int PERIOD = 10;
  localparam int NSTEP  = 21;

  typedef struct packed {
    logic [7:0] src;
    logic       wr;
    logic [1:0] addr;
    logic [1:0] op;
    logic [2:0] bsel;
    logic [7:0] data;
    logic       ack;
    logic       reti;
    logic       irq;
    logic [2:0] vec;
    logic [3:0] req;
  } step_t;

  // src, wr, addr, op, bit, data, ack, reti | expected irq, vec | requirement
  localparam step_t TBL [NSTEP] = '{
    '{8'h00, 1'b0, 2'd0, 2'd3, 3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 3'd0, 4'd1}, // R1 idle
    '{8'h08, 1'b0, 2'd0, 2'd3, 3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 3'd0, 4'd4}, // R4 flag, no enable
    '{8'h08, 1'b1, 2'd0, 2'd0, 3'd0, 8'h0C, 1'b0, 1'b0, 1'b0, 3'd3, 4'd5}, // R5 vec without master
    '{8'h08, 1'b1, 2'd2, 2'd1, 3'd0, 8'h00, 1'b0, 1'b0, 1'b1, 3'd3, 4'd3}, // R3 set master bit
    '{8'h0C, 1'b0, 2'd0, 2'd3, 3'd0, 8'h00, 1'b0, 1'b0, 1'b1, 3'd2, 4'd5}, // R5 lower index wins
    '{8'h0C, 1'b0, 2'd0, 2'd3, 3'd0, 8'h00, 1'b1, 1'b0, 1'b0, 3'd3, 4'd6}, // R6 entry
    '{8'h0C, 1'b0, 2'd0, 2'd3, 3'd0, 8'h00, 1'b0, 1'b1, 1'b1, 3'd3, 4'd7}, // R7 return
    '{8'h0C, 1'b0, 2'd0, 2'd3, 3'd0, 8'h00, 1'b1, 1'b0, 1'b0, 3'd0, 4'd2}, // R2 held level no retrigger
    '{8'h00, 1'b0, 2'd0, 2'd3, 3'd0, 8'h00, 1'b0, 1'b1, 1'b0, 3'd0, 4'd4}, // R4 master but nothing pending
    '{8'h01, 1'b0, 2'd0, 2'd3, 3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 3'd0, 4'd4}, // R4 disabled source
    '{8'h01, 1'b1, 2'd0, 2'd1, 3'd0, 8'h00, 1'b0, 1'b0, 1'b1, 3'd0, 4'd3}, // R3 set enable bit
    '{8'h01, 1'b1, 2'd1, 2'd2, 3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 3'd0, 4'd3}, // R3 clear flag bit
    '{8'h01, 1'b1, 2'd1, 2'd0, 3'd0, 8'h0C, 1'b0, 1'b0, 1'b1, 3'd2, 4'd3}, // R3 load flags
    '{8'h05, 1'b0, 2'd0, 2'd3, 3'd0, 8'h00, 1'b1, 1'b0, 1'b0, 3'd2, 4'd9}, // R9 edge beats ack
    '{8'h05, 1'b1, 2'd2, 2'd1, 3'd0, 8'h00, 1'b0, 1'b0, 1'b1, 3'd2, 4'd8}, // R8 nesting
    '{8'h05, 1'b0, 2'd0, 2'd3, 3'd0, 8'h00, 1'b1, 1'b1, 1'b0, 3'd3, 4'd7}, // R7 ack beats return
    '{8'h05, 1'b1, 2'd3, 2'd0, 3'd0, 8'hFF, 1'b0, 1'b0, 1'b0, 3'd3, 4'd3}, // R3 address 3 ignored
    '{8'h05, 1'b1, 2'd2, 2'd3, 3'd0, 8'hFF, 1'b0, 1'b0, 1'b0, 3'd3, 4'd3}, // R3 op 3 ignored
    '{8'h05, 1'b1, 2'd2, 2'd0, 3'd0, 8'h01, 1'b0, 1'b0, 1'b1, 3'd3, 4'd3}, // R3 load control
    '{8'h05, 1'b1, 2'd2, 2'd2, 3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 3'd3, 4'd3}, // R3 clear master bit
    '{8'h05, 1'b1, 2'd0, 2'd0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 3'd0, 4'd5}  // R5 none enabled
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] src_i = '0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [1:0] wr_op_i = 2'd3;
  logic [2:0] wr_bit_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       ack_i = 1'b0;
  logic       reti_i = 1'b0;
  logic       irq_o;
  logic [2:0] vec_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(PERIOD / 2) clk = ~clk;

  intc_core uut (
    .clk      (clk),
    .rst      (rst),
    .src_i    (src_i),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_op_i  (wr_op_i),
    .wr_bit_i (wr_bit_i),
    .wr_data_i(wr_data_i),
    .ack_i    (ack_i),
    .reti_i   (reti_i),
    .irq_o    (irq_o),
    .vec_o    (vec_o)
  );

  task automatic check(input string tag, input logic exp_irq, input logic [2:0] exp_vec);
    checks++;
    if (irq_o !== exp_irq || vec_o !== exp_vec) begin
      failures++;
      $display("FAIL %s irq=%0b vec=%0d expected irq=%0b vec=%0d",
               tag, irq_o, vec_o, exp_irq, exp_vec);
    end
  endtask

  task automatic drive(input step_t s);
    src_i     = s.src;
    wr_en_i   = s.wr;
    wr_addr_i = s.addr;
    wr_op_i   = s.op;
    wr_bit_i  = s.bsel;
    wr_data_i = s.data;
    ack_i     = s.ack;
    reti_i    = s.reti;
  endtask

  task automatic write(input logic [1:0] a, input logic [1:0] op,
                       input logic [2:0] b, input logic [7:0] d);
    drive('{src_i, 1'b1, a, op, b, d, 1'b0, 1'b0, 1'b0, 3'd0, 4'd0});
  endtask

  task automatic idle();
    drive('{src_i, 1'b0, 2'd0, 2'd3, 3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 3'd0, 4'd0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", 1'b0, 3'd0);
    rst = 1'b0;

    for (int k = 0; k < NSTEP; k++) begin
      drive(TBL[k]);
      @(negedge clk);
      check($sformatf("R%0d step %0d", TBL[k].req, k), TBL[k].irq, TBL[k].vec);
    end

    // reset in the middle of activity: flags 0x08, enables 0
    write(2'd0, 2'd0, 3'd0, 8'hFF);
    @(negedge clk);
    check("R4 enables loaded, master off", 1'b0, 3'd3);
    write(2'd2, 2'd1, 3'd0, 8'h00);
    @(negedge clk);
    check("R4 master on", 1'b1, 3'd3);
    idle();
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset", 1'b0, 3'd0);
    rst = 1'b0;
    write(2'd1, 2'd0, 3'd0, 8'hFF);
    @(negedge clk);
    check("R1 enables cleared by reset", 1'b0, 3'd0);
    write(2'd2, 2'd1, 3'd0, 8'h00);
    @(negedge clk);
    check("R1 master on, enables still clear", 1'b0, 3'd0);
    write(2'd0, 2'd0, 3'd0, 8'h80);
    @(negedge clk);
    check("R5 top index alone", 1'b1, 3'd7);
    write(2'd2, 2'd1, 3'd1, 8'h00);
    @(negedge clk);
    check("R3 set of non-master control bit", 1'b1, 3'd7);
    idle();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired before the run ended");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule